// File: doc/BRIEF.md
# Packed Signed Greater-Than Comparator

This block is a SIMD compare stage for a vector datapath. It takes two 256-bit operand vectors and splits them into lanes of 8, 16 or 32 bits. Each lane pair is compared as signed two's-complement integers. Every bit of the result lane is set to one when the first operand's lane is strictly greater than the second's, and cleared to zero otherwise. The result is a per-lane mask that later select or blend logic can use directly.

A mode select sets the active width: 64, 128 or 256 bits. It also sets what happens to the destination bits above that width. They are either passed through from an old-destination input or forced to zero. The 256-bit mode runs as two independent 128-bit halves. A reserved lane-size code and an illegal vector-length request in the 128-bit modes are each reported on a flag of their own.

All outputs are registered with one cycle of latency and a synchronous active-high reset. A valid bit travels alongside each result.

Top module: `vec_sgt_cmp`

## Requirements
- R1: With lane_sel = 0 (8-bit lanes), each byte lane of the active width in res is 8'hFF when the opa byte is signed-greater than the opb byte, and 8'h00 otherwise.
- R2: With lane_sel = 1 (16-bit lanes), each 16-bit lane of the active width follows the same signed strict greater-than mask rule.
- R3: With lane_sel = 2 (32-bit lanes), each 32-bit lane of the active width follows the same signed strict greater-than mask rule.
- R4: Equal lanes give an all-zero lane. A lane holding the most negative value (only the sign bit set) in opa gives an all-zero lane against any opb value. The most positive value in opa gives all ones against any smaller opb value.
- R5: With mode_sel = 0 (64-bit), only bits 63:0 are compared, and res bits 255:64 equal old_dst bits 255:64.
- R6: With mode_sel = 1 (128-bit, keep upper), bits 127:0 are compared, and res bits 255:128 equal old_dst bits 255:128.
- R7: With mode_sel = 2 (128-bit, zero upper), bits 127:0 are compared, and res bits 255:128 are zero.
- R8: With mode_sel = 3 (256-bit), both the lower and the upper 128-bit halves are compared, each lane independently.
- R9: lane_sel = 3 is reserved. It gives res equal to all zeros and size_err = 1. For lane_sel 0 to 2, size_err = 0.
- R10: len_err is 1 exactly when mode_sel is 1 or 2 and vlen_bit is 1. In that case res is still produced, but it must not be used.
- R11: On the clock edge after in_valid is sampled, out_valid is 1, and res, len_err and size_err reflect the inputs sampled at that edge. out_valid is 0 otherwise.
- R12: While rst is high at a clock edge, out_valid, res, len_err and size_err are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| lane_sel | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| mode_sel | input | 2 | 0 = 64-bit, 1 = 128-bit keep upper, 2 = 128-bit zero upper, 3 = 256-bit |
| vlen_bit | input | 1 | Vector-length request bit, illegal in the 128-bit modes |
| old_dst | input | 256 | Previous destination value |
| opa | input | 256 | First operand (compared as greater) |
| opb | input | 256 | Second operand |
| out_valid | output | 1 | Result registers hold a new result |
| res | output | 256 | Lane mask result merged with the upper destination bits |
| len_err | output | 1 | Illegal vector length in a 128-bit mode |
| size_err | output | 1 | Reserved lane-size code used |

## Verification
Any fault in this block shows up at the ports one cycle after the operands arrive, because nothing is held across operations. A lane compare that treats values as unsigned would flip the mask for lanes that straddle the sign boundary. Lane values 0x80.., 0x7F.. and equal operands expose that at once. A wrong width or mode decode damages whole groups of lanes or the upper destination bits, and the scoreboard catches it on the first affected vector. The random vectors run through every lane-size and mode pairing, which exposes swapped or misrouted halves.

// File: rtl/vec_sgt_pkg.sv
package vec_sgt_pkg;
  typedef enum logic [1:0] {
    LS_8   = 2'd0,
    LS_16  = 2'd1,
    LS_32  = 2'd2,
    LS_RSV = 2'd3
  } lane_size_e;

  typedef enum logic [1:0] {
    MD_64      = 2'd0,
    MD_128KEEP = 2'd1,
    MD_128ZERO = 2'd2,
    MD_256     = 2'd3
  } width_mode_e;

  localparam int NUM_SIZES = 3;
  localparam int MIN_LANE  = 8;
endpackage

// File: rtl/vec_sgt_lanes.sv
module vec_sgt_lanes #(
  parameter int DW = 128,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] mask
);
  localparam int NL = DW / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic gt;
    assign gt = $signed(a[i*LW +: LW]) > $signed(b[i*LW +: LW]);
    assign mask[i*LW +: LW] = {LW{gt}};
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      if (a[i*LW +: LW] == b[i*LW +: LW]) begin
        // R4
        eq_lane_zero_chk: assert (mask[i*LW +: LW] == '0);
      end
      if (a[i*LW +: LW] == {1'b1, {(LW-1){1'b0}}}) begin
        // R4
        min_lane_zero_chk: assert (mask[i*LW +: LW] == '0);
      end
    end
  end
endmodule

// File: rtl/vec_sgt_half.sv
module vec_sgt_half
  import vec_sgt_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lane_size_e    size,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] by_size [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    vec_sgt_lanes #(.DW(DW), .LW(MIN_LANE << k)) u_lanes (
      .a    (a),
      .b    (b),
      .mask (by_size[k])
    );
  end

  always_comb begin
    case (size)
      LS_8:    mask = by_size[0];
      LS_16:   mask = by_size[1];
      LS_32:   mask = by_size[2];
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/vec_sgt_merge.sv
module vec_sgt_merge
  import vec_sgt_pkg::*;
#(
  parameter int VW     = 256,
  parameter int HALF   = 128,
  parameter int NARROW = 64
) (
  input  logic [VW-1:0] cmp,
  input  logic [VW-1:0] old,
  input  width_mode_e   mode,
  input  logic          rsv,
  output logic [VW-1:0] res
);
  always_comb begin
    res = cmp;
    case (mode)
      MD_64: begin
        res = old;
        res[NARROW-1:0] = cmp[NARROW-1:0];
      end
      MD_128KEEP: begin
        res = old;
        res[HALF-1:0] = cmp[HALF-1:0];
      end
      MD_128ZERO: begin
        res = '0;
        res[HALF-1:0] = cmp[HALF-1:0];
      end
      default: res = cmp;
    endcase
    if (rsv) res = '0;
  end
endmodule

// File: rtl/vec_sgt_cmp.sv
module vec_sgt_cmp
  import vec_sgt_pkg::*;
#(
  parameter int VW     = 256,
  parameter int HALF   = 128,
  parameter int NARROW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    lane_sel,
  input  logic [1:0]    mode_sel,
  input  logic          vlen_bit,
  input  logic [VW-1:0] old_dst,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  output logic          out_valid,
  output logic [VW-1:0] res,
  output logic          len_err,
  output logic          size_err
);
  localparam int NH = VW / HALF;

  lane_size_e  size;
  width_mode_e mode;
  logic [VW-1:0] cmp_all;
  logic [VW-1:0] merged;
  logic          rsv;
  logic          len_bad;

  assign size    = lane_size_e'(lane_sel);
  assign mode    = width_mode_e'(mode_sel);
  assign rsv     = (size == LS_RSV);
  assign len_bad = vlen_bit && (mode == MD_128KEEP || mode == MD_128ZERO);

  for (genvar h = 0; h < NH; h++) begin : g_half
    vec_sgt_half #(.DW(HALF)) u_half (
      .a    (opa[h*HALF +: HALF]),
      .b    (opb[h*HALF +: HALF]),
      .size (size),
      .mask (cmp_all[h*HALF +: HALF])
    );
  end

  vec_sgt_merge #(.VW(VW), .HALF(HALF), .NARROW(NARROW)) u_merge (
    .cmp  (cmp_all),
    .old  (old_dst),
    .mode (mode),
    .rsv  (rsv),
    .res  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      len_err   <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res      <= merged;
        len_err  <= len_bad;
        size_err <= rsv;
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && size_err) |-> (res == '0));

  // R5
  keep64_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd0 && lane_sel != 2'd3)
      |=> (res[VW-1:NARROW] == $past(old_dst[VW-1:NARROW])));

  // R6
  keep128_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd1 && lane_sel != 2'd3)
      |=> (res[VW-1:HALF] == $past(old_dst[VW-1:HALF])));

  // R7
  zero128_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd2) |=> (res[VW-1:HALF] == '0));

  // R10
  len_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=> !len_err);
endmodule

// File: tb/tb_vec_sgt_cmp.sv
`timescale 1ns/1ps
module tb_vec_sgt_cmp;
  typedef struct {
    logic [255:0] r;
    logic         le;
    logic         se;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   lane_sel = '0;
  logic [1:0]   mode_sel = '0;
  logic         vlen_bit = 1'b0;
  logic [255:0] old_dst = '0;
  logic [255:0] opa = '0;
  logic [255:0] opb = '0;
  logic         out_valid;
  logic [255:0] res;
  logic         len_err;
  logic         size_err;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  vec_sgt_cmp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sel(lane_sel),
    .mode_sel(mode_sel), .vlen_bit(vlen_bit), .old_dst(old_dst),
    .opa(opa), .opb(opb), .out_valid(out_valid), .res(res),
    .len_err(len_err), .size_err(size_err)
  );

  function automatic exp_t model(logic [255:0] od, logic [255:0] a, logic [255:0] b,
                                 logic [1:0] ls, logic [1:0] md, logic vl, string tag);
    exp_t e;
    int w, act;
    logic [31:0] x, y;
    logic g;
    e.tag = tag;
    e.le  = (md == 2'd1 || md == 2'd2) && vl;
    e.se  = (ls == 2'd3);
    if (ls == 2'd3) begin
      e.r = '0;
    end else begin
      w   = 8 << ls;
      act = (md == 2'd0) ? 64 : ((md == 2'd3) ? 256 : 128);
      e.r = (md == 2'd2) ? 256'd0 : od;
      for (int i = 0; i < act; i += w) begin
        x = '0; y = '0;
        for (int k = 0; k < w; k++) begin x[k] = a[i+k]; y[k] = b[i+k]; end
        x[w-1] = ~x[w-1];
        y[w-1] = ~y[w-1];
        g = (x > y);
        for (int k = 0; k < w; k++) e.r[i+k] = g;
      end
    end
    return e;
  endfunction

  task automatic drive(logic [255:0] od, logic [255:0] a, logic [255:0] b,
                       logic [1:0] ls, logic [1:0] md, logic vl, string tag);
    @(negedge clk);
    old_dst = od; opa = a; opb = b; lane_sel = ls; mode_sel = md; vlen_bit = vl;
    in_valid = 1'b1;
    q.push_back(model(od, a, b, ls, md, vl, tag));
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] fill(int w, logic [31:0] val);
    logic [255:0] v;
    for (int i = 0; i < 256; i += w)
      for (int k = 0; k < w; k++) v[i+k] = val[k];
    return v;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      exp_t e;
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: out_valid=1 with no pending item, expected out_valid=0");
      end else begin
        e = q.pop_front();
        if (res !== e.r || len_err !== e.le || size_err !== e.se) begin
          n_bad++;
          $display("FAIL %s: res=%h le=%0b se=%0b expected res=%h le=%0b se=%0b",
                   e.tag, res, len_err, size_err, e.r, e.le, e.se);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, od;
    repeat (3) @(negedge clk);
    // R12 reset state, inputs active during reset
    in_valid = 1'b1; lane_sel = 2'd3; vlen_bit = 1'b1; mode_sel = 2'd1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || res !== '0 || len_err !== 1'b0 || size_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R12: ov=%0b res=%h le=%0b se=%0b expected all zero",
               out_valid, res, len_err, size_err);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: out_valid=%0b expected 0 when idle", out_valid);
    end

    od = rnd256();
    // R4 boundary values for each lane size, 256-bit mode
    for (int ls = 0; ls < 3; ls++) begin
      int w = 8 << ls;
      logic [31:0] mn = 32'h1 << (w - 1);
      logic [31:0] mx = mn - 1;
      drive(od, fill(w, mn), fill(w, mx), ls[1:0], 2'd3, 1'b0, "R4 min-vs-max");
      drive(od, fill(w, mx), fill(w, mn), ls[1:0], 2'd3, 1'b0, "R4 max-vs-min");
      a = rnd256();
      drive(od, a, a, ls[1:0], 2'd3, 1'b0, "R4 equal");
      drive(od, fill(w, mn), rnd256(), ls[1:0], 2'd3, 1'b0, "R4 min-vs-any");
      drive(od, fill(w, 32'hFFFF_FFFF), fill(w, 0), ls[1:0], 2'd3, 1'b0, "R4 neg1-vs-0");
    end
    // R1 R2 R3 with mixed sign patterns
    drive(od, {32{8'h01}}, {32{8'hFF}}, 2'd0, 2'd3, 1'b0, "R1");
    drive(od, {16{16'h8000}}, {16{16'h7FFF}}, 2'd1, 2'd3, 1'b0, "R2");
    drive(od, {8{32'h0000_0001}}, {8{32'h8000_0000}}, 2'd2, 2'd3, 1'b0, "R3");
    // R5 R6 R7 R8 modes
    drive(od, rnd256(), rnd256(), 2'd0, 2'd0, 1'b1, "R5");
    drive(od, rnd256(), rnd256(), 2'd1, 2'd1, 1'b0, "R6");
    drive(od, rnd256(), rnd256(), 2'd2, 2'd2, 1'b0, "R7");
    drive(od, {{128{1'b0}}, {128{1'b1}}}, {{128{1'b1}}, {128{1'b0}}}, 2'd0, 2'd3, 1'b0, "R8");
    // R9 reserved size in every mode
    for (int md = 0; md < 4; md++)
      drive(od, rnd256(), rnd256(), 2'd3, md[1:0], 1'b0, "R9");
    // R10 length flag across modes
    for (int md = 0; md < 4; md++) begin
      drive(od, rnd256(), rnd256(), 2'd1, md[1:0], 1'b1, "R10 vlen=1");
      drive(od, rnd256(), rnd256(), 2'd1, md[1:0], 1'b0, "R10 vlen=0");
    end
    // R11 gap cycle between items
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: out_valid=%0b expected 0 after idle input", out_valid);
    end
    // random sweep across all selects (R1 R2 R3 R8)
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ls = 2'($urandom_range(0, 3));
      logic [1:0] md = 2'($urandom_range(0, 3));
      a = rnd256();
      b = ($urandom_range(0, 7) == 0) ? a : rnd256();
      if ($urandom_range(0, 3) == 0) b[63:0] = a[63:0];
      drive(rnd256(), a, b, ls, md, 1'($urandom), "R1/R2/R3/R8 random");
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: %0d results missing, expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule